// File: doc/BRIEF.md
# Two-Wire Bus Slave Address Front End

This block is the receive side of a two-wire serial slave. It samples the clock and data lines of the bus with a small always-on sampling clock and passes each line through a synchronizer and a glitch filter. It then watches the cleaned lines for bus conditions. A falling data line while the clock is high opens a transfer, whether or not a transfer is already running. A rising data line while the clock is high closes the transfer.

After every opening condition the block shifts in one byte: a seven-bit address followed by a direction bit. It compares the address with a programmable own address. When enabled, it also compares the address with the all-zero broadcast address. On a hit it raises a match flag and reports the direction. It also tells whether the hit came from the broadcast compare. During the ninth clock pulse it pulls the data line low when acknowledging is enabled. An external abort strobe, for example from another wake source, drops a pending or completed match and returns the block to idle.

Top module: `twb_addr_front`

## Requirements
- R1: An opening condition is the cleaned data line going from 1 to 0 while the cleaned clock line is 1 on two consecutive samples. It gives exactly one one-cycle pulse on `start_o`, also when it repeats inside a transfer. A closing condition is the data line going from 0 to 1 while the clock line is held at 1. It gives exactly one one-cycle pulse on `stop_o`.
- R2: A level on either bus input that lasts fewer than `FILT_CYC` sampling cycles is ignored. With the default of 3, a 2-cycle low glitch on the data line while the clock is high produces no `start_o` pulse.
- R3: After each opening condition the block takes 8 bits, one on each rising clock edge, most significant bit first. Bits 7:1 form the address and bit 0 is the direction. On a match, `rw_o` shows the direction bit (1 = read).
- R4: A nonzero address equal to `own_addr_i` sets `match_o` = 1 and `gcall_o` = 0. An own address of zero is never matched through the own compare.
- R5: The address 7'b0000000 matches only while `gc_en_i` = 1. It then sets `match_o` = 1 and `gcall_o` = 1. With `gc_en_i` = 0 it leaves both flags at 0.
- R6: `ack_low_o` is 1 from the clock fall after the eighth bit to the clock fall after the ninth bit only when the byte matched and `ack_en_i` = 1. Otherwise the data line is released during the ninth bit.
- R7: A one-cycle `abort_i` clears `match_o`, `gcall_o`, `rw_o` and `ack_low_o` on the next cycle. The block then stays idle until the next opening condition.
- R8: A closing condition clears the match flags. A new opening condition clears them and starts a fresh byte, so a repeated opening condition re-evaluates the address.
- R9: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line (as seen on the wire) |
| own_addr_i | input | ADDR_W | Programmable own address |
| gc_en_i | input | 1 | Enable for the broadcast (all-zero) address compare |
| ack_en_i | input | 1 | Enable for acknowledging a matched address |
| abort_i | input | 1 | Strobe that drops the match and returns to idle |
| start_o | output | 1 | One-cycle pulse on an opening condition |
| stop_o | output | 1 | One-cycle pulse on a closing condition |
| match_o | output | 1 | Address matched in the current transfer |
| gcall_o | output | 1 | The match came from the broadcast address |
| rw_o | output | 1 | Direction bit of the matched address byte |
| ack_low_o | output | 1 | Pull the data line low (acknowledge) |

## Verification
The address compare is swept over all 128 received addresses. The sweep runs under four settings of own address, broadcast enable and acknowledge enable. Together these separate own hits from broadcast hits, show that address zero is refused without the enable, and show that an own address of zero never matches. The sweep also shows that the acknowledge follows the enable and not the match alone. Directed sequences cover a sub-filter glitch that must not open a transfer, a repeated opening condition that changes the verdict without a closing condition, and an abort raised while the acknowledge is being driven.

// File: rtl/twb_pkg.sv
package twb_pkg;
   typedef enum logic [2:0] {
      RX_IDLE,
      RX_ADDR,
      RX_ACK_WAIT,
      RX_ACK_DRV,
      RX_HELD
   } rx_state_t;
endpackage

// File: rtl/twb_line_filter.sv
module twb_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYC    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic clean_o
);
   localparam int CNT_W = (FILT_CYC > 1) ? $clog2(FILT_CYC + 1) : 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("twb_line_filter: SYNC_STAGES must be at least 2");
      end
      if (FILT_CYC < 1) begin : g_bad_filt
         $error("twb_line_filter: FILT_CYC must be at least 1");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   samp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end
   assign samp = sync_q[SYNC_STAGES-1];

   generate
      if (FILT_CYC == 1) begin : g_pass
         logic line_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_q <= 1'b1;
            else        line_q <= samp;
         end
         assign clean_o = line_q;
      end else begin : g_count
         logic             line_q;
         logic [CNT_W-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               line_q <= 1'b1;
               run_q  <= '0;
            end else if (samp == line_q) begin
               run_q <= '0;
            end else if (run_q == CNT_W'(FILT_CYC - 1)) begin
               line_q <= samp;
               run_q  <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
         assign clean_o = line_q;
      end
   endgenerate
endmodule

// File: rtl/twb_cond_detect.sv
module twb_cond_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic open_ev,
   output logic close_ev
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   assign scl_rise = scl & ~scl_q;
   assign scl_fall = ~scl & scl_q;
   assign open_ev  = scl & scl_q & sda_q & ~sda;
   assign close_ev = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/twb_addr_rx.sv
module twb_addr_rx
   import twb_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              open_ev,
   input  logic              close_ev,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              gc_en,
   input  logic              ack_en,
   input  logic              abort,
   output logic              match,
   output logic              gcall,
   output logic              rw,
   output logic              ack_low
);
   localparam int BYTE_W = ADDR_W + 1;
   localparam int CNT_W  = $clog2(BYTE_W + 1);

   rx_state_t         state_q;
   logic [BYTE_W-1:0] shift_q;
   logic [CNT_W-1:0]  bits_q;
   logic [BYTE_W-1:0] byte_nxt;
   logic [ADDR_W-1:0] addr_rx;
   logic              own_hit, gc_hit, last_bit;

   always_comb begin
      byte_nxt = {shift_q[BYTE_W-2:0], sda};
      addr_rx  = byte_nxt[BYTE_W-1:1];
      own_hit  = (addr_rx == own_addr) && (addr_rx != '0);
      gc_hit   = gc_en && (addr_rx == '0);
      last_bit = (bits_q == CNT_W'(BYTE_W - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         shift_q <= '0;
         bits_q  <= '0;
         match   <= 1'b0;
         gcall   <= 1'b0;
         rw      <= 1'b0;
         ack_low <= 1'b0;
      end else if (abort || close_ev) begin
         state_q <= RX_IDLE;
         match   <= 1'b0;
         gcall   <= 1'b0;
         rw      <= 1'b0;
         ack_low <= 1'b0;
      end else if (open_ev) begin
         state_q <= RX_ADDR;
         shift_q <= '0;
         bits_q  <= '0;
         match   <= 1'b0;
         gcall   <= 1'b0;
         rw      <= 1'b0;
         ack_low <= 1'b0;
      end else begin
         unique case (state_q)
            RX_ADDR: begin
               if (scl_rise) begin
                  shift_q <= byte_nxt;
                  bits_q  <= bits_q + 1'b1;
                  if (last_bit) begin
                     if (own_hit || gc_hit) begin
                        match   <= 1'b1;
                        gcall   <= gc_hit;
                        rw      <= byte_nxt[0];
                        state_q <= RX_ACK_WAIT;
                     end else begin
                        state_q <= RX_IDLE;
                     end
                  end
               end
            end
            RX_ACK_WAIT: begin
               if (scl_fall) begin
                  ack_low <= ack_en;
                  state_q <= RX_ACK_DRV;
               end
            end
            RX_ACK_DRV: begin
               if (scl_fall) begin
                  ack_low <= 1'b0;
                  state_q <= RX_HELD;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/twb_addr_front.sv
module twb_addr_front #(
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYC    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              gc_en_i,
   input  logic              ack_en_i,
   input  logic              abort_i,
   output logic              start_o,
   output logic              stop_o,
   output logic              match_o,
   output logic              gcall_o,
   output logic              rw_o,
   output logic              ack_low_o
);
   localparam int N_LINES = 2;

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("twb_addr_front: ADDR_W must be at least 1");
      end
   endgenerate

   logic [N_LINES-1:0] raw_lines, clean_lines;
   logic scl_rise, scl_fall, open_ev, close_ev;

   assign raw_lines = {scl_i, sda_i};

   generate
      for (genvar i = 0; i < N_LINES; i++) begin : g_line
         twb_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_CYC   (FILT_CYC)
         ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_lines[i]),
            .clean_o(clean_lines[i])
         );
      end
   endgenerate

   twb_cond_detect u_cond (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl     (clean_lines[1]),
      .sda     (clean_lines[0]),
      .scl_rise(scl_rise),
      .scl_fall(scl_fall),
      .open_ev (open_ev),
      .close_ev(close_ev)
   );

   twb_addr_rx #(.ADDR_W(ADDR_W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .open_ev (open_ev),
      .close_ev(close_ev),
      .scl_rise(scl_rise),
      .scl_fall(scl_fall),
      .sda     (clean_lines[0]),
      .own_addr(own_addr_i),
      .gc_en   (gc_en_i),
      .ack_en  (ack_en_i),
      .abort   (abort_i),
      .match   (match_o),
      .gcall   (gcall_o),
      .rw      (rw_o),
      .ack_low (ack_low_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_o <= 1'b0;
         stop_o  <= 1'b0;
      end else begin
         start_o <= open_ev;
         stop_o  <= close_ev;
      end
   end
endmodule

// File: rtl/twb_addr_front_chk.sv
module twb_addr_front_chk #(
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_i,
   input logic [ADDR_W-1:0] own_addr_i,
   input logic              gc_en_i,
   input logic              ack_en_i,
   input logic              abort_i,
   input logic              start_o,
   input logic              stop_o,
   input logic              match_o,
   input logic              gcall_o,
   input logic              rw_o,
   input logic              ack_low_o
);
   AST_COND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_o && stop_o)); // R1
   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o); // R1
   AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_o |=> !stop_o); // R1
   AST_GCALL_IMPLIES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      gcall_o |-> match_o); // R5
   AST_GCALL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gcall_o) |-> $past(gc_en_i)); // R5
   AST_ACK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      ack_low_o |-> match_o); // R6
   AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> (!match_o && !gcall_o && !rw_o && !ack_low_o)); // R7
   AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      stop_o |-> (!match_o && !ack_low_o)); // R8
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> !match_o); // R8
endmodule

bind twb_addr_front twb_addr_front_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/twb_addr_front_bench.sv
module twb_addr_front_bench;
   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       drv_scl = 1'b1;
   logic       drv_sda = 1'b1;
   logic [6:0] own_addr = 7'h2A;
   logic       gc_en = 1'b0;
   logic       ack_en = 1'b0;
   logic       abort = 1'b0;
   logic       start_o, stop_o, match_o, gcall_o, rw_o, ack_low_o;
   logic       bus_sda;

   int n_checks = 0;
   int n_errors = 0;
   int n_start  = 0;
   int n_stop   = 0;
   logic ack_seen;

   always #2.5 clk = ~clk;

   assign bus_sda = drv_sda & ~ack_low_o;

   twb_addr_front u_twb_addr_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (drv_scl),
      .sda_i     (bus_sda),
      .own_addr_i(own_addr),
      .gc_en_i   (gc_en),
      .ack_en_i  (ack_en),
      .abort_i   (abort),
      .start_o   (start_o),
      .stop_o    (stop_o),
      .match_o   (match_o),
      .gcall_o   (gcall_o),
      .rw_o      (rw_o),
      .ack_low_o (ack_low_o)
   );

   always @(posedge clk) begin
      if (rst_n && start_o) n_start <= n_start + 1;
      if (rst_n && stop_o)  n_stop  <= n_stop + 1;
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic bus_open();
      drv_sda = 1'b1; cyc(HALF);
      drv_scl = 1'b1; cyc(HALF);
      drv_sda = 1'b0; cyc(HALF);
      drv_scl = 1'b0;
   endtask

   task automatic bus_bit(input logic b);
      cyc(2);
      drv_sda = b; cyc(HALF);
      drv_scl = 1'b1; cyc(HALF);
      drv_scl = 1'b0;
   endtask

   task automatic bus_ack_bit();
      cyc(2);
      drv_sda = 1'b1; cyc(HALF);
      drv_scl = 1'b1; cyc(HALF / 2);
      ack_seen = !bus_sda;
      cyc(HALF - HALF / 2);
      drv_scl = 1'b0;
   endtask

   task automatic bus_close();
      cyc(2);
      drv_sda = 1'b0; cyc(HALF);
      drv_scl = 1'b1; cyc(HALF);
      drv_sda = 1'b1; cyc(HALF);
   endtask

   task automatic bus_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) bus_bit(b[i]);
   endtask

   task automatic sweep(input logic [6:0] own, input logic gce, input logic acke);
      own_addr = own; gc_en = gce; ack_en = acke;
      for (int a = 0; a < 128; a++) begin
         logic [6:0] ad;
         logic       rwb, own_hit, gc_hit, hit;
         int         s0, p0;
         ad = 7'(a);
         rwb = ad[0] ^ ad[3];
         own_hit = (ad == own) && (ad != 7'd0);
         gc_hit  = gce && (ad == 7'd0);
         hit     = own_hit || gc_hit;
         s0 = n_start; p0 = n_stop;
         bus_open();
         bus_byte({ad, rwb});
         bus_ack_bit();
         check(match_o == hit, (ad == 7'd0) ? "R5 match" : "R4 match", match_o, hit);
         check(gcall_o == gc_hit, (ad == 7'd0) ? "R5 gcall" : "R4 gcall", gcall_o, gc_hit);
         if (hit) check(rw_o == rwb, "R3 rw", rw_o, rwb);
         check(ack_seen == (hit && acke), "R6 ack", ack_seen, hit && acke);
         bus_close();
         check(n_start == s0 + 1, "R1 start count", n_start, s0 + 1);
         check(n_stop == p0 + 1, "R1 stop count", n_stop, p0 + 1);
         check(match_o == 1'b0, "R8 cleared by stop", match_o, 0);
      end
   endtask

   initial begin : watchdog
      repeat (195000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin : main
      cyc(5);
      rst_n = 1'b1;
      cyc(2);
      // R9 reset state
      check({start_o, stop_o, match_o, gcall_o, rw_o, ack_low_o} == 6'b0, "R9 reset",
            {start_o, stop_o, match_o, gcall_o, rw_o, ack_low_o}, 0);
      cyc(20);

      // R2: 2-cycle glitch on data while clock is high
      begin
         int s0;
         s0 = n_start;
         drv_sda = 1'b0; cyc(2);
         drv_sda = 1'b1; cyc(20);
         check(n_start == s0, "R2 glitch ignored", n_start, s0);
         check(match_o == 1'b0, "R2 no transfer", match_o, 0);
      end

      // Exhaustive address sweeps (R3, R4, R5, R6)
      sweep(7'h2A, 1'b1, 1'b1);
      sweep(7'h2A, 1'b0, 1'b0);
      sweep(7'h00, 1'b0, 1'b1);
      sweep(7'h7F, 1'b1, 1'b0);

      // R8: repeated open condition re-evaluates the address
      begin
         int s0, p0;
         own_addr = 7'h15; gc_en = 1'b0; ack_en = 1'b1;
         s0 = n_start; p0 = n_stop;
         bus_open();
         bus_byte({7'h15, 1'b1});
         bus_ack_bit();
         check(match_o == 1'b1, "R8 first byte match", match_o, 1);
         check(rw_o == 1'b1, "R3 read direction", rw_o, 1);
         bus_open();
         check(match_o == 1'b0, "R8 repeated open clears", match_o, 0);
         bus_byte({7'h16, 1'b0});
         bus_ack_bit();
         check(match_o == 1'b0, "R8 second byte mismatch", match_o, 0);
         check(ack_seen == 1'b0, "R6 no ack on mismatch", ack_seen, 0);
         check(n_start == s0 + 2, "R1 repeated open pulses", n_start, s0 + 2);
         check(n_stop == p0, "R1 no close in between", n_stop, p0);
         bus_close();
      end

      // R7: abort while acknowledge is being driven
      begin
         own_addr = 7'h33; gc_en = 1'b0; ack_en = 1'b1;
         bus_open();
         bus_byte({7'h33, 1'b0});
         cyc(HALF);
         check(ack_low_o == 1'b1, "R6 ack driven after eighth bit", ack_low_o, 1);
         abort = 1'b1; cyc(1);
         abort = 1'b0; cyc(1);
         check(match_o == 1'b0, "R7 abort clears match", match_o, 0);
         check(ack_low_o == 1'b0, "R7 abort releases ack", ack_low_o, 0);
         drv_sda = 1'b1; cyc(HALF);
         drv_scl = 1'b1; cyc(HALF / 2);
         check(bus_sda == 1'b1, "R7 line released in ninth bit", bus_sda, 1);
         cyc(HALF - HALF / 2);
         drv_scl = 1'b0;
         bus_byte({7'h33, 1'b0});
         check(match_o == 1'b0, "R7 idle until next open", match_o, 0);
         bus_close();
      end

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule